// File: doc/BRIEF.md
# Shared Channel Buffer Contention Arbiter

This block owns a small byte buffer shared by two users. One is a parallel host that reaches it through a chip select, a read/write flag, an address and data lines, with no timing tie to the block's clock. The other is a serial time-division engine that touches one byte per channel slot, in step with the block's clock. The bit shifting and the frame counting of the serial engine are outside the block. They arrive here as a window flag, an access flag, the current channel address and the serial write data.

A clash is recognised only when both users aim at the same byte while the serial engine's window is open. The window covers the final serial clock period of each channel. The serial access itself occupies only the second half of that period. When a clash occurs the serial engine always goes first. The host access is parked and then carried out exactly once after the window closes.

The host learns of a clash in one of two ways, chosen by a mode pin. In RAM-style mode an active-low BUSY output asks the host to wait. In strobe/acknowledge mode BUSY stays quiet and the active-low acknowledge is held back instead. These two outputs are the only back-pressure on the host side. The host must keep its address, direction and write data steady from the falling chip select until it sees completion: the acknowledge, or the end of BUSY. The serial side has no back-pressure, because it always wins.

Top module: `dpbuf_arb`

## Requirements
- R1: After reset busy_n and ack_n are high, h_rdata is 0 and every buffer byte reads 0.
- R2: A host access that begins with no same-address window open completes on the third rising clock edge after cs_n falls. A write stores h_wdata at h_addr. A read presents the byte on h_rdata. In acknowledge mode (mode=1) ack_n goes low at that same edge.
- R3: A host access whose address differs from ser_addr never conflicts. busy_n stays high and the access completes at the R2 latency, even while slot_win or slot_acc is high.
- R4: In RAM-style mode (mode=0), a host access that begins while slot_win is high and h_addr equals ser_addr drives busy_n low. This happens from the second rising edge after cs_n falls. busy_n stays low until the rising edge after slot_win falls, at which point the held access is carried out.
- R5: The serial side has priority. A serial write (ser_wr during slot_acc) lands in the clashing slot before the held host access. The held access is then performed once, so a held read returns the serial write's data and a held write leaves the host's value.
- R6: In acknowledge mode busy_n never goes low. A conflicting access keeps ack_n high until the held access is performed after the window.
- R7: A host access that started before the window and is still held during the window's first half (slot_win high, slot_acc low) raises no BUSY.
- R8: In RAM-style mode, while a synchronised host request is held and slot_acc is high with a matching address, busy_n is low. busy_n returns high once slot_acc drops. slot_acc is only ever high while slot_win is high.
- R9: In acknowledge mode ack_n returns high on the third rising edge after cs_n rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial-domain clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode | input | 1 | 0 = RAM-style BUSY signalling, 1 = strobe/acknowledge signalling |
| cs_n | input | 1 | Host chip select, active low, asynchronous |
| rd_wr_n | input | 1 | Host direction: 1 read, 0 write |
| h_addr | input | AW | Host byte address |
| h_wdata | input | DW | Host write data |
| h_rdata | output | DW | Host read data, registered |
| busy_n | output | 1 | Active-low busy, RAM-style mode only |
| ack_n | output | 1 | Active-low acknowledge, strobe/acknowledge mode only |
| slot_win | input | 1 | Contention window: last serial clock period of a channel |
| slot_acc | input | 1 | Serial access period: second half of the window |
| ser_addr | input | AW | Byte address of the current channel |
| ser_wr | input | 1 | Serial side writes ser_wdata during slot_acc |
| ser_wdata | input | DW | Serial write data |
| ser_rdata | output | DW | Byte at ser_addr, combinational |

## Verification
A free host access lands on the third rising edge after cs_n falls: two edges of synchronisation, then one edge to execute. The acknowledge and the read data therefore appear together, and the acknowledge clears three edges after cs_n rises. BUSY for an access that starts inside the window is visible after the second edge. BUSY for an access held into the serial slot follows slot_acc within the same cycle. A parked access runs on the first edge after slot_win drops. The bench drives every input at a falling edge and samples at the falling edge after the exact count of rising edges. A scoreboard pairs each acknowledge edge with the queued expected read value.

// File: rtl/dpbuf_pkg.sv
package dpbuf_pkg;
  typedef enum logic {
    SIG_BUSY = 1'b0,
    SIG_ACK  = 1'b1
  } sig_mode_e;
endpackage

// File: rtl/dpbuf_sync.sv
module dpbuf_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= 1'b0;
    else        chain[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[i] <= 1'b0;
      else        chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/dpbuf_conflict.sv
module dpbuf_conflict #(
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] h_addr,
  input  logic [AW-1:0] ser_addr,
  input  logic          slot_win,
  input  logic          slot_acc,
  output logic          hit_win,
  output logic          hit_acc
);
  logic same;

  assign same    = (h_addr == ser_addr);
  assign hit_win = slot_win & same;
  assign hit_acc = slot_acc & same;

  // R8: the serial access period always lies inside the window
  p_acc_in_win_r8: assert property (@(posedge clk) disable iff (!rst_n)
    slot_acc |-> slot_win);
endmodule

// File: rtl/dpbuf_mem.sv
module dpbuf_mem #(
  parameter int AW = 5,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ser_we,
  input  logic [AW-1:0] ser_addr,
  input  logic [DW-1:0] ser_wdata,
  output logic [DW-1:0] ser_rdata,
  input  logic          host_we,
  input  logic          host_re,
  input  logic [AW-1:0] host_addr,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
    end else begin
      if (ser_we)  cells[ser_addr]  <= ser_wdata;
      if (host_we) cells[host_addr] <= host_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       host_rdata <= '0;
    else if (host_re) host_rdata <= cells[host_addr];
  end

  assign ser_rdata = cells[ser_addr];

  // R5: a host write never lands on the byte the serial side writes in the same cycle
  p_serial_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (host_we && ser_we) |-> (host_addr != ser_addr));
endmodule

// File: rtl/dpbuf_arb.sv
module dpbuf_arb
  import dpbuf_pkg::*;
#(
  parameter int AW          = 5,
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode,
  input  logic          cs_n,
  input  logic          rd_wr_n,
  input  logic [AW-1:0] h_addr,
  input  logic [DW-1:0] h_wdata,
  output logic [DW-1:0] h_rdata,
  output logic          busy_n,
  output logic          ack_n,
  input  logic          slot_win,
  input  logic          slot_acc,
  input  logic [AW-1:0] ser_addr,
  input  logic          ser_wr,
  input  logic [DW-1:0] ser_wdata,
  output logic [DW-1:0] ser_rdata
);
  sig_mode_e sig_mode;
  logic req, req_q, start, blocked, exec, pending, done;
  logic hit_win, hit_acc;

  assign sig_mode = sig_mode_e'(mode);

  dpbuf_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(~cs_n), .q(req)
  );

  dpbuf_conflict #(.AW(AW)) u_conf (
    .clk(clk), .rst_n(rst_n), .h_addr(h_addr), .ser_addr(ser_addr),
    .slot_win(slot_win), .slot_acc(slot_acc),
    .hit_win(hit_win), .hit_acc(hit_acc)
  );

  assign start   = req & ~req_q;
  assign blocked = hit_win;
  assign exec    = (start | pending) & ~blocked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q   <= 1'b0;
      pending <= 1'b0;
      done    <= 1'b0;
    end else begin
      req_q <= req;
      if (start && blocked) pending <= 1'b1;
      else if (exec)        pending <= 1'b0;
      if (exec)      done <= 1'b1;
      else if (!req) done <= 1'b0;
    end
  end

  dpbuf_mem #(.AW(AW), .DW(DW)) u_mem (
    .clk(clk), .rst_n(rst_n),
    .ser_we(slot_acc & ser_wr), .ser_addr(ser_addr),
    .ser_wdata(ser_wdata), .ser_rdata(ser_rdata),
    .host_we(exec & ~rd_wr_n), .host_re(exec & rd_wr_n),
    .host_addr(h_addr), .host_wdata(h_wdata), .host_rdata(h_rdata)
  );

  assign busy_n = ~((sig_mode == SIG_BUSY) &
                    ((start & blocked) | pending | (req & hit_acc)));
  assign ack_n  = ~((sig_mode == SIG_ACK) & done);

  // R4: a parked access stays parked while its window is still open
  p_hold_in_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && hit_win) |=> pending);

  // R5: a parked access is carried out once, never twice in a row
  p_exec_once_r5: assert property (@(posedge clk) disable iff (!rst_n)
    exec |=> !exec);

  // R6: no acknowledge while an access is parked
  p_ack_withheld_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pending |-> ack_n);

  // R6: a completed access and a parked one never coexist
  p_done_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && pending));
endmodule

// File: tb/dpbuf_arb_bench.sv
`timescale 1ns/1ps
module dpbuf_arb_bench;
  localparam int AW = 5;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n, mode, cs_n, rd_wr_n, busy_n, ack_n;
  logic slot_win, slot_acc, ser_wr;
  logic [AW-1:0] h_addr, ser_addr;
  logic [DW-1:0] h_wdata, h_rdata, ser_wdata, ser_rdata;

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  typedef struct {
    bit            is_rd;
    logic [DW-1:0] data;
    string         tag;
  } exp_t;
  exp_t sb[$];

  always #4 clk = ~clk;

  dpbuf_arb #(.AW(AW), .DW(DW)) u_dpbuf_arb (
    .clk(clk), .rst_n(rst_n), .mode(mode), .cs_n(cs_n), .rd_wr_n(rd_wr_n),
    .h_addr(h_addr), .h_wdata(h_wdata), .h_rdata(h_rdata),
    .busy_n(busy_n), .ack_n(ack_n),
    .slot_win(slot_win), .slot_acc(slot_acc), .ser_addr(ser_addr),
    .ser_wr(ser_wr), .ser_wdata(ser_wdata), .ser_rdata(ser_rdata)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic push(bit is_rd, logic [DW-1:0] d, string tag);
    exp_t e;
    e.is_rd = is_rd;
    e.data  = d;
    e.tag   = tag;
    sb.push_back(e);
  endtask

  task automatic host_go(bit rd, logic [AW-1:0] a, logic [DW-1:0] d);
    rd_wr_n = rd;
    h_addr  = a;
    h_wdata = d;
    cs_n    = 1'b0;
  endtask

  // monitor: each acknowledge falling edge retires one scoreboard entry
  logic prev_ack = 1'b1;
  always @(negedge clk) begin
    if (rst_n && prev_ack && !ack_n) begin
      if (sb.size() == 0) begin
        check("R6 unexpected ack", 32'd1, 32'd0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        if (e.is_rd) check(e.tag, h_rdata, e.data);
        else         check(e.tag, 32'd1, 32'd1);
      end
    end
    prev_ack = ack_n;
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; mode = 1'b1; cs_n = 1'b1; rd_wr_n = 1'b1;
    h_addr = '0; h_wdata = '0;
    slot_win = 1'b0; slot_acc = 1'b0; ser_addr = '0; ser_wr = 1'b0; ser_wdata = '0;
    @(negedge clk);
    @(negedge clk);
    check("R1 busy_n", busy_n, 1);
    check("R1 ack_n", ack_n, 1);
    check("R1 h_rdata", h_rdata, 0);
    rst_n = 1'b1;
    ser_addr = 5'd9;
    step(1);
    check("R1 ser_rdata", ser_rdata, 0);

    // R2 / R9: free write and read in acknowledge mode
    push(0, 8'h00, "R2 write ack");
    host_go(0, 5'd3, 8'h5A);
    step(2);
    check("R2 ack not early", ack_n, 1);
    step(1);
    check("R2 ack on third edge", ack_n, 0);
    cs_n = 1'b1;
    step(2);
    check("R9 ack still held", ack_n, 0);
    step(1);
    check("R9 ack released", ack_n, 1);
    push(1, 8'h5A, "R2 read back");
    host_go(1, 5'd3, 8'h00);
    step(3);
    cs_n = 1'b1;
    step(3);

    // R3: different address inside the window, RAM-style mode
    mode = 1'b0;
    slot_win = 1'b1; ser_addr = 5'd7;
    host_go(0, 5'd4, 8'h3C);
    step(2);
    check("R3 busy_n start", busy_n, 1);
    slot_acc = 1'b1; ser_wr = 1'b1; ser_wdata = 8'h99;
    step(1);
    check("R3 busy_n in slot", busy_n, 1);
    slot_win = 1'b0; slot_acc = 1'b0; ser_wr = 1'b0;
    cs_n = 1'b1;
    step(3);
    host_go(1, 5'd4, 8'h00);
    step(3);
    check("R3 write landed", h_rdata, 8'h3C);
    cs_n = 1'b1;
    step(3);
    ser_addr = 5'd7;
    step(1);
    check("R3 serial write landed", ser_rdata, 8'h99);

    // R4 / R5: same address, access starts inside the window
    slot_win = 1'b1; ser_addr = 5'd3; ser_wr = 1'b1; ser_wdata = 8'h77;
    host_go(0, 5'd3, 8'h11);
    step(2);
    check("R4 busy immediate", busy_n, 0);
    slot_acc = 1'b1;
    step(1);
    check("R4 busy held", busy_n, 0);
    check("R5 serial write first", ser_rdata, 8'h77);
    step(1);
    check("R4 busy to end", busy_n, 0);
    slot_win = 1'b0; slot_acc = 1'b0; ser_wr = 1'b0;
    step(1);
    check("R4 busy released", busy_n, 1);
    cs_n = 1'b1;
    step(3);
    host_go(1, 5'd3, 8'h00);
    step(3);
    check("R5 held write applied after", h_rdata, 8'h11);
    cs_n = 1'b1;
    step(3);

    // R6 / R5: acknowledge mode conflict, held read sees serial data
    mode = 1'b1;
    slot_win = 1'b1; ser_addr = 5'd3; ser_wr = 1'b1; ser_wdata = 8'h22;
    push(1, 8'h22, "R5 held read gets serial data");
    host_go(1, 5'd3, 8'h00);
    step(2);
    check("R6 no busy", busy_n, 1);
    check("R6 ack withheld", ack_n, 1);
    slot_acc = 1'b1;
    step(2);
    check("R6 ack withheld in slot", ack_n, 1);
    check("R6 no busy in slot", busy_n, 1);
    slot_win = 1'b0; slot_acc = 1'b0; ser_wr = 1'b0;
    step(1);
    check("R6 ack after window", ack_n, 0);
    cs_n = 1'b1;
    step(3);

    // R7: started before window, held through first half only
    mode = 1'b0;
    ser_addr = 5'd0;
    host_go(1, 5'd5, 8'h00);
    step(3);
    check("R7 read before window", h_rdata, 8'h00);
    slot_win = 1'b1; ser_addr = 5'd5;
    step(1);
    check("R7 no busy first half", busy_n, 1);
    step(1);
    check("R7 no busy first half 2", busy_n, 1);
    slot_win = 1'b0;
    cs_n = 1'b1;
    step(3);

    // R8: held into the serial access period
    ser_addr = 5'd0;
    host_go(1, 5'd5, 8'h00);
    step(3);
    slot_win = 1'b1; ser_addr = 5'd5;
    step(1);
    check("R8 no busy before slot", busy_n, 1);
    slot_acc = 1'b1;
    step(1);
    check("R8 busy in slot", busy_n, 0);
    slot_acc = 1'b0; slot_win = 1'b0;
    step(1);
    check("R8 busy cleared", busy_n, 1);
    cs_n = 1'b1;
    step(3);

    check("R6 scoreboard drained", sb.size(), 0);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule